// File: doc/BRIEF.md
# Scan Buffer Host Interface

This block sits between a host processor and a string-matching engine. The host loads one chunk of text into an on-chip byte buffer and writes the chunk length. It then writes a start command, and the block hands the chunk to the engine with a one-cycle start pulse. While the engine scans, it reads bytes through a read port and streams match records (pattern ID and byte offset) back into a small result store. When the engine signals completion, a sticky done flag is set and, if enabled, the interrupt line rises. The host then reads the match count and the stored records, clears done, and loads the next chunk. Long inputs are scanned as a series of such chunks, with one start per chunk.

Host access is a single-cycle register/memory bus. A write takes effect on the clock edge where `host_wr` is high. Reads are combinational from `host_addr`. The top two address bits select a region: 0 is registers, 1 is the text buffer (one byte per word), 2 is the stored pattern IDs, and 3 is the stored offsets. The low bits give the register offset or the entry index. Registers are at these offsets: 0 control (bit 0 run, bit 1 interrupt enable), 1 length, 2 start command (write bit 0 = 1), 3 status (bit 0 busy, bit 1 done, bit 2 error, bit 3 overflow), and 4 stored match count.

The match stream is valid/ready. `res_ready` is high exactly while a chunk is busy. Every beat with `res_valid` and `res_ready` both high is taken in that cycle, and the stream never stalls. When the store is full, an accepted beat is discarded rather than back-pressured. Beats offered while idle are not taken.

Top module: `scan_buf_host_if`

## Requirements
- R1: After reset, status reads 0 (not busy, no done, no error, no overflow), the count reads 0, and `irq`, `eng_start`, `eng_abort` and `res_ready` are low.
- R2: While idle, a host write to text region index i stores the low byte. That byte reads back at host text index i and appears on `eng_rd_data` when `eng_rd_addr` is i. A length write while idle is stored, read back at register 1 and driven on `eng_len`.
- R3: A start-command write with bit 0 set, while run (control bit 0) is 1 and the block is idle, makes busy read 1 and raises `eng_start` for exactly one cycle after that edge. The same start clears done, the count and overflow. A start-command write while run is 0 has no effect.
- R4: `eng_done` while busy clears busy and sets done (status bit 1). Done stays set until the host writes status with bit 1 set. A done set and a clear on the same edge leave done set.
- R5: `irq` is high exactly when done is set and interrupt enable (control bit 1) is 1.
- R6: Each accepted beat while busy stores its pattern ID at pattern region index n and its offset at offset region index n, where n is the count before the beat. The count then increases by one. Beats offered while idle are not stored.
- R7: Once the count equals the store depth, further accepted beats are discarded, the count holds, and overflow (status bit 3) is set until the next start.
- R8: While busy, host writes to the text region or the length register leave their contents unchanged and set error (status bit 2). Writing status with bit 2 set clears error.
- R9: A control write with run cleared while busy ends the chunk. Busy reads 0 and `eng_abort` pulses for one cycle, with done left clear. If `eng_done` falls in the same cycle, done is set and there is no abort pulse.
- R10: A beat accepted in the same cycle as `eng_done` is stored and counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_wr | input | 1 | Host write strobe |
| host_addr | input | ADDR_W | Host address (region in top two bits) |
| host_wdata | input | DATA_W | Host write data |
| host_rdata | output | DATA_W | Host read data, combinational from host_addr |
| irq | output | 1 | Interrupt: done and enable |
| eng_start | output | 1 | One-cycle start pulse to the engine |
| eng_abort | output | 1 | One-cycle stop pulse to the engine |
| eng_len | output | LEN_W | Chunk length in bytes |
| eng_rd_addr | input | TXT_AW | Engine text read index |
| eng_rd_data | output | 8 | Engine text read byte |
| eng_done | input | 1 | Engine chunk-complete pulse |
| res_valid | input | 1 | Match beat valid |
| res_ready | output | 1 | Match beat accepted (high while busy) |
| res_pat_id | input | PAT_W | Pattern ID of the match |
| res_offset | input | LEN_W | Byte offset of the match |

## Verification
Two events can meet on one edge. A final match beat can arrive together with `eng_done`, and a host stop can arrive together with `eng_done`. The bench drives the beat and the completion on the same cycle, then judges the outcome from the host side: the count must include that last record, done must be set and busy cleared. It also drives a control write with run cleared on the completion cycle and expects done set with no abort pulse, which separates the completion path from the stop path.

// File: rtl/sbh_pkg.sv
package sbh_pkg;
  typedef enum logic [1:0] {
    RGN_REG  = 2'd0,
    RGN_TEXT = 2'd1,
    RGN_RPAT = 2'd2,
    RGN_ROFS = 2'd3
  } rgn_e;

  localparam int OFS_CTRL = 0;
  localparam int OFS_LEN  = 1;
  localparam int OFS_GO   = 2;
  localparam int OFS_STAT = 3;
  localparam int OFS_CNT  = 4;

  localparam int BIT_RUN   = 0;
  localparam int BIT_IRQEN = 1;
  localparam int BIT_BUSY  = 0;
  localparam int BIT_DONE  = 1;
  localparam int BIT_ERR   = 2;
  localparam int BIT_OVF   = 3;
endpackage

// File: rtl/sbh_text_buf.sv
module sbh_text_buf #(
  parameter int DEPTH = 16,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [7:0]    wr_data,
  input  logic [AW-1:0] rd_a_addr,
  output logic [7:0]    rd_a_data,
  input  logic [AW-1:0] rd_b_addr,
  output logic [7:0]    rd_b_data
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  assign rd_a_data = mem[rd_a_addr];
  assign rd_b_data = mem[rd_b_addr];
endmodule

// File: rtl/sbh_result_buf.sv
module sbh_result_buf #(
  parameter int DEPTH = 4,
  parameter int PAT_W = 8,
  parameter int OFS_W = 5,
  parameter int RAW   = $clog2(DEPTH),
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             push,
  input  logic [PAT_W-1:0] pat,
  input  logic [OFS_W-1:0] ofs,
  input  logic [RAW-1:0]   rd_idx,
  output logic [PAT_W-1:0] rd_pat,
  output logic [OFS_W-1:0] rd_ofs,
  output logic [CNT_W-1:0] count,
  output logic             ovf
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

  logic [PAT_W-1:0] pat_mem [DEPTH];
  logic [OFS_W-1:0] ofs_mem [DEPTH];
  logic             full;

  assign full = (count == FULL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count <= '0;
      ovf   <= 1'b0;
    end else if (clear) begin
      count <= '0;
      ovf   <= 1'b0;
    end else if (push) begin
      if (full) ovf <= 1'b1;
      else      count <= count + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (push && !full && !clear) begin
      pat_mem[count[RAW-1:0]] <= pat;
      ofs_mem[count[RAW-1:0]] <= ofs;
    end
  end

  assign rd_pat = pat_mem[rd_idx];
  assign rd_ofs = ofs_mem[rd_idx];

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    count <= FULL); // R7
  AST_OVF_ON_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !clear) |=> (ovf && $stable(count))); // R7
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !full && !clear) |=> (count == $past(count) + 1'b1)); // R6
endmodule

// File: rtl/sbh_ctrl.sv
module sbh_ctrl #(
  parameter int LEN_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctrl_wr,
  input  logic             go_wr,
  input  logic             stat_wr,
  input  logic             len_wr,
  input  logic             text_wr,
  input  logic [2:0]       wflags,
  input  logic [LEN_W-1:0] wlen,
  input  logic             eng_done,
  output logic             run,
  output logic             irq_en,
  output logic [LEN_W-1:0] len,
  output logic             busy,
  output logic             done,
  output logic             err,
  output logic             start_p,
  output logic             abort_p,
  output logic             start_now,
  output logic             text_ok,
  output logic             irq
);
  import sbh_pkg::*;

  logic finish;
  logic stop;

  assign start_now = go_wr && wflags[0] && run && !busy;
  assign finish    = busy && eng_done;
  assign stop      = busy && ctrl_wr && !wflags[BIT_RUN] && !eng_done;
  assign text_ok   = text_wr && !busy;
  assign irq       = done && irq_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run     <= 1'b0;
      irq_en  <= 1'b0;
      len     <= '0;
      busy    <= 1'b0;
      done    <= 1'b0;
      err     <= 1'b0;
      start_p <= 1'b0;
      abort_p <= 1'b0;
    end else begin
      start_p <= start_now;
      abort_p <= stop;
      if (ctrl_wr) begin
        run    <= wflags[BIT_RUN];
        irq_en <= wflags[BIT_IRQEN];
      end
      if (len_wr && !busy) len <= wlen;
      if (start_now)          busy <= 1'b1;
      else if (finish || stop) busy <= 1'b0;
      if (start_now)                        done <= 1'b0;
      else if (finish)                      done <= 1'b1;
      else if (stat_wr && wflags[BIT_DONE]) done <= 1'b0;
      if (busy && (text_wr || len_wr))      err <= 1'b1;
      else if (stat_wr && wflags[BIT_ERR])  err <= 1'b0;
    end
  end

  AST_START_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    start_p |-> (busy && !$past(busy))); // R3
  AST_DONE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(eng_done && busy)); // R4
  AST_ABORT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    abort_p |-> (!busy && !done)); // R9
  AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err) |-> $past(busy && (text_wr || len_wr))); // R8
endmodule

// File: rtl/scan_buf_host_if.sv
module scan_buf_host_if #(
  parameter int DATA_W     = 32,
  parameter int ADDR_W     = 8,
  parameter int TEXT_DEPTH = 16,
  parameter int RES_DEPTH  = 4,
  parameter int PAT_W      = 8,
  parameter int LEN_W      = $clog2(TEXT_DEPTH + 1),
  parameter int TXT_AW     = $clog2(TEXT_DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic [DATA_W-1:0] host_wdata,
  output logic [DATA_W-1:0] host_rdata,
  output logic              irq,
  output logic              eng_start,
  output logic              eng_abort,
  output logic [LEN_W-1:0]  eng_len,
  input  logic [TXT_AW-1:0] eng_rd_addr,
  output logic [7:0]        eng_rd_data,
  input  logic              eng_done,
  input  logic              res_valid,
  output logic              res_ready,
  input  logic [PAT_W-1:0]  res_pat_id,
  input  logic [LEN_W-1:0]  res_offset
);
  import sbh_pkg::*;

  localparam int IDX_W = ADDR_W - 2;
  localparam int RAW   = $clog2(RES_DEPTH);
  localparam int CNT_W = $clog2(RES_DEPTH + 1);

  rgn_e             rgn;
  logic [IDX_W-1:0] idx;
  logic             reg_wr;
  logic             ctrl_wr, go_wr, stat_wr, len_wr, text_wr;
  logic             run, irq_en, busy, done, err, start_now, text_ok;
  logic [LEN_W-1:0] len;
  logic [7:0]       host_text;
  logic [PAT_W-1:0] rd_pat;
  logic [LEN_W-1:0] rd_ofs;
  logic [CNT_W-1:0] count;
  logic             ovf;
  logic             push;
  logic             unused_wdata;

  assign rgn     = rgn_e'(host_addr[ADDR_W-1 -: 2]);
  assign idx     = host_addr[IDX_W-1:0];
  assign reg_wr  = host_wr && (rgn == RGN_REG);
  assign ctrl_wr = reg_wr && (idx == IDX_W'(OFS_CTRL));
  assign len_wr  = reg_wr && (idx == IDX_W'(OFS_LEN));
  assign go_wr   = reg_wr && (idx == IDX_W'(OFS_GO));
  assign stat_wr = reg_wr && (idx == IDX_W'(OFS_STAT));
  assign text_wr = host_wr && (rgn == RGN_TEXT);
  assign unused_wdata = ^host_wdata;

  assign res_ready = busy;
  assign push      = res_valid && busy;
  assign eng_len   = len;

  sbh_ctrl #(.LEN_W(LEN_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .ctrl_wr(ctrl_wr), .go_wr(go_wr), .stat_wr(stat_wr),
    .len_wr(len_wr), .text_wr(text_wr),
    .wflags(host_wdata[2:0]), .wlen(host_wdata[LEN_W-1:0]),
    .eng_done(eng_done),
    .run(run), .irq_en(irq_en), .len(len), .busy(busy), .done(done),
    .err(err), .start_p(eng_start), .abort_p(eng_abort),
    .start_now(start_now), .text_ok(text_ok), .irq(irq)
  );

  sbh_text_buf #(.DEPTH(TEXT_DEPTH), .AW(TXT_AW)) u_text (
    .clk(clk),
    .wr_en(text_ok), .wr_addr(host_addr[TXT_AW-1:0]), .wr_data(host_wdata[7:0]),
    .rd_a_addr(host_addr[TXT_AW-1:0]), .rd_a_data(host_text),
    .rd_b_addr(eng_rd_addr), .rd_b_data(eng_rd_data)
  );

  sbh_result_buf #(.DEPTH(RES_DEPTH), .PAT_W(PAT_W), .OFS_W(LEN_W),
                   .RAW(RAW), .CNT_W(CNT_W)) u_res (
    .clk(clk), .rst_n(rst_n),
    .clear(start_now), .push(push), .pat(res_pat_id), .ofs(res_offset),
    .rd_idx(host_addr[RAW-1:0]), .rd_pat(rd_pat), .rd_ofs(rd_ofs),
    .count(count), .ovf(ovf)
  );

  always_comb begin
    host_rdata = '0;
    unique case (rgn)
      RGN_REG: begin
        if (idx == IDX_W'(OFS_CTRL)) begin
          host_rdata[BIT_RUN]   = run;
          host_rdata[BIT_IRQEN] = irq_en;
        end else if (idx == IDX_W'(OFS_LEN)) begin
          host_rdata = DATA_W'(len);
        end else if (idx == IDX_W'(OFS_STAT)) begin
          host_rdata[BIT_BUSY] = busy;
          host_rdata[BIT_DONE] = done;
          host_rdata[BIT_ERR]  = err;
          host_rdata[BIT_OVF]  = ovf;
        end else if (idx == IDX_W'(OFS_CNT)) begin
          host_rdata = DATA_W'(count);
        end
      end
      RGN_TEXT: host_rdata = DATA_W'(host_text);
      RGN_RPAT: host_rdata = DATA_W'(rd_pat);
      RGN_ROFS: host_rdata = DATA_W'(rd_ofs);
      default:  host_rdata = '0;
    endcase
  end

  AST_READY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> $stable(count)); // R6
  AST_IRQ_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> (eng_done || $past(eng_done) || $past(host_wr))); // R5
endmodule

// File: tb/scan_buf_host_if_tb_top.sv
module scan_buf_host_if_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 8;
  localparam int TEXT_DEPTH = 16;
  localparam int RES_DEPTH = 4;
  localparam int PAT_W = 8;
  localparam int LEN_W = $clog2(TEXT_DEPTH + 1);
  localparam int TXT_AW = $clog2(TEXT_DEPTH);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_wr = 1'b0;
  logic [ADDR_W-1:0] host_addr = '0;
  logic [DATA_W-1:0] host_wdata = '0;
  logic [DATA_W-1:0] host_rdata;
  logic irq, eng_start, eng_abort, res_ready;
  logic [LEN_W-1:0] eng_len;
  logic [TXT_AW-1:0] eng_rd_addr = '0;
  logic [7:0] eng_rd_data;
  logic eng_done = 1'b0;
  logic res_valid = 1'b0;
  logic [PAT_W-1:0] res_pat_id = '0;
  logic [LEN_W-1:0] res_offset = '0;

  int checks = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  scan_buf_host_if dut_i (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .irq(irq),
    .eng_start(eng_start), .eng_abort(eng_abort), .eng_len(eng_len),
    .eng_rd_addr(eng_rd_addr), .eng_rd_data(eng_rd_data), .eng_done(eng_done),
    .res_valid(res_valid), .res_ready(res_ready), .res_pat_id(res_pat_id),
    .res_offset(res_offset)
  );

  function automatic logic [ADDR_W-1:0] a(input int rgn, input int ix);
    return ADDR_W'((rgn << (ADDR_W - 2)) | ix);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic hw(input logic [ADDR_W-1:0] ad, input logic [31:0] d);
    @(negedge clk);
    host_wr = 1'b1; host_addr = ad; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic hr(input logic [ADDR_W-1:0] ad, output logic [31:0] d);
    host_addr = ad;
    #1;
    d = host_rdata;
  endtask

  task automatic beat(input logic [7:0] p, input logic [4:0] o, input logic fin);
    @(negedge clk);
    res_valid = 1'b1; res_pat_id = p; res_offset = o; eng_done = fin;
    @(negedge clk);
    res_valid = 1'b0; eng_done = 1'b0;
  endtask

  task automatic finish_chunk;
    @(negedge clk);
    eng_done = 1'b1;
    @(negedge clk);
    eng_done = 1'b0;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    hr(a(0, 3), d); chk("R1 status", d, 0);
    hr(a(0, 4), d); chk("R1 count", d, 0);
    chk("R1 outputs", {irq, eng_start, eng_abort, res_ready}, 0);
  endtask

  task automatic t_load;
    logic [31:0] d;
    for (int i = 0; i < 4; i++) hw(a(1, i), 32'h10 + i);
    hw(a(0, 1), 4);
    hr(a(1, 2), d); chk("R2 text readback", d, 32'h12);
    eng_rd_addr = 3; #1; chk("R2 engine read", eng_rd_data, 8'h13);
    hr(a(0, 1), d); chk("R2 length readback", d, 4);
    chk("R2 eng_len", eng_len, 4);
  endtask

  task automatic t_start;
    logic [31:0] d;
    hw(a(0, 2), 1);
    hr(a(0, 3), d); chk("R3 start ignored when run=0", d, 0);
    chk("R3 no pulse when run=0", eng_start, 0);
    hw(a(0, 0), 3);
    hw(a(0, 2), 1);
    chk("R3 start pulse", eng_start, 1);
    hr(a(0, 3), d); chk("R3 busy", d, 1);
    @(negedge clk);
    chk("R3 pulse one cycle", eng_start, 0);
    chk("R6 ready while busy", res_ready, 1);
  endtask

  task automatic t_results;
    logic [31:0] d;
    beat(8'hA1, 5'd2, 1'b0);
    beat(8'hB2, 5'd7, 1'b0);
    hr(a(0, 4), d); chk("R6 count", d, 2);
    hr(a(2, 1), d); chk("R6 pattern id", d, 8'hB2);
    hr(a(3, 0), d); chk("R6 offset", d, 2);
    beat(8'hC3, 5'd9, 1'b1);
    hr(a(0, 4), d); chk("R10 beat with done counted", d, 3);
    hr(a(2, 2), d); chk("R10 beat with done stored", d, 8'hC3);
    hr(a(0, 3), d); chk("R4 done set busy clear", d, 2);
    chk("R5 irq on", irq, 1);
    hw(a(0, 0), 1);
    chk("R5 irq off when disabled", irq, 0);
    chk("R6 ready low idle", res_ready, 0);
    beat(8'hDD, 5'd1, 1'b0);
    hr(a(0, 4), d); chk("R6 idle beat not stored", d, 3);
    hr(a(0, 3), d); chk("R4 done sticky", d, 2);
    hw(a(0, 3), 2);
    hr(a(0, 3), d); chk("R4 done cleared", d, 0);
  endtask

  task automatic t_busy_err;
    logic [31:0] d;
    hw(a(0, 2), 1);
    hr(a(0, 4), d); chk("R3 start clears count", d, 0);
    hw(a(1, 0), 32'hEE);
    hw(a(0, 1), 9);
    hr(a(0, 3), d); chk("R8 error set", d, 32'h5);
    hr(a(1, 0), d); chk("R8 text unchanged", d, 32'h10);
    hr(a(0, 1), d); chk("R8 length unchanged", d, 4);
    hw(a(0, 3), 4);
    hr(a(0, 3), d); chk("R8 error cleared", d, 1);
  endtask

  task automatic t_overflow;
    logic [31:0] d;
    for (int i = 0; i < 6; i++) beat(8'h40 + 8'(i), 5'(i), 1'b0);
    hr(a(0, 4), d); chk("R7 count held at depth", d, RES_DEPTH);
    hr(a(0, 3), d); chk("R7 overflow set", d, 32'h9);
    hr(a(2, 3), d); chk("R7 last stored entry", d, 8'h43);
    finish_chunk;
    hw(a(0, 3), 2);
    hw(a(0, 2), 1);
    hr(a(0, 3), d); chk("R7 overflow cleared by start", d, 1);
  endtask

  task automatic t_stop;
    logic [31:0] d;
    hw(a(0, 0), 0);
    chk("R9 abort pulse", eng_abort, 1);
    hr(a(0, 3), d); chk("R9 stopped no done", d, 0);
    @(negedge clk);
    chk("R9 abort one cycle", eng_abort, 0);
    hw(a(0, 0), 1);
    hw(a(0, 2), 1);
    @(negedge clk);
    host_wr = 1'b1; host_addr = a(0, 0); host_wdata = 0; eng_done = 1'b1;
    @(negedge clk);
    host_wr = 1'b0; eng_done = 1'b0;
    chk("R9 done wins, no abort", eng_abort, 0);
    hr(a(0, 3), d); chk("R9 done set on collision", d, 2);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_load;
    t_start;
    t_results;
    t_busy_err;
    t_overflow;
    t_stop;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule